// File: doc/BRIEF.md
# Unlock-Code Detector for Nonvolatile Store and Recall

This block sits beside an SRAM-compatible memory port. It watches the address presented during each chip-enable-framed access. It looks for a fixed six-access unlock code made only of reads. The final address of the code chooses between two requests: copy the volatile array into nonvolatile storage (store), or load it back (recall). When the code completes, the block issues a one-cycle request pulse. The engine that performs the transfer lives elsewhere.

An access counts once, when chip enable is released. The block looks at the last address captured while enable was low, and at whether write enable was low at any point in that access. Output enable has no role, so the code is recognised whether or not the data pins are driven. A power-supervision flag can veto store requests. A busy input from the transfer engine freezes detection while a transfer runs.

Top module: `nvu_unlock_detect`

## Requirements
- R1: After reset, `progress_o` is 0 and neither request output is high.
- R2: Six consecutive reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F raise `store_req_o` for exactly one clock, in the cycle after the sixth access ends. `progress_o` returns to 0 in that same cycle.
- R3: The same five-read prefix followed by a read of 0x0F0E raises `recall_req_o` for exactly one clock. `progress_o` returns to 0.
- R4: `progress_o` reports the number of code reads matched so far (0 to 5). It changes only in the cycle after chip enable goes high. An access that holds enable low for several clocks counts once.
- R5: An access during which write enable was low aborts the code. `progress_o` becomes 0, even if the address matches the expected step.
- R6: A read whose address is not the expected next step sets `progress_o` to 0. If that address is 0x0000, `progress_o` is set to 1 instead.
- R7: The reserved test code (the five-read prefix followed by 0x139C) produces no request and leaves `progress_o` at 0.
- R8: When `store_block_i` is high as the sixth access ends, no store pulse is produced. A recall code completed in the same way still produces its pulse.
- R9: While `xfer_busy_i` is high, `progress_o` is held at 0, accesses are ignored and no request pulse is produced.
- R10: `store_req_o` and `recall_req_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 13 | Memory address bus |
| chip_en_n | input | 1 | Chip enable, active low; frames one access |
| wr_en_n | input | 1 | Write enable, active low |
| store_block_i | input | 1 | High while supply is below the store threshold |
| xfer_busy_i | input | 1 | High while a store or recall transfer runs |
| store_req_o | output | 1 | One-cycle store request |
| recall_req_o | output | 1 | One-cycle recall request |
| progress_o | output | 3 | Code steps matched so far |

## Verification
The embedded properties check on every cycle that the two request pulses never overlap and each lasts one clock. They also check that a pulse follows only from the last step, that progress moves only when an access ends and only by one step or to a restart value, and that the busy and store-block inputs suppress what they should. Only the directed scenarios can show the address-level behaviour: which exact code values cause a store or a recall, that the reserved test code stays silent, that a write to a matching address still aborts, and that a long enable-low access counts once.

// File: rtl/nvu_pkg.sv
package nvu_pkg;
  localparam int ADDR_W  = 13;
  localparam int N_STEPS = 6;
  localparam int CNT_W   = $clog2(N_STEPS);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef enum logic [1:0] {ACT_NONE, ACT_STORE, ACT_RECALL} act_e;

  localparam cnt_t  LAST_IDX   = cnt_t'(N_STEPS - 1);
  localparam addr_t KEY_STORE  = addr_t'(13'h0F0F);
  localparam addr_t KEY_RECALL = addr_t'(13'h0F0E);
  localparam addr_t KEY_START  = addr_t'(13'h0000);

  // address expected at prefix position idx (0..4)
  function automatic addr_t key_at(cnt_t idx);
    case (idx)
      3'd0:    return addr_t'(13'h0000);
      3'd1:    return addr_t'(13'h1555);
      3'd2:    return addr_t'(13'h0AAA);
      3'd3:    return addr_t'(13'h1FFF);
      3'd4:    return addr_t'(13'h10F0);
      default: return addr_t'(13'h0000);
    endcase
  endfunction

  // progress after a read in one of the prefix positions
  function automatic cnt_t step_after(cnt_t cur, addr_t a);
    if (a == key_at(cur))  return cur + cnt_t'(1);
    else if (a == KEY_START) return cnt_t'(1);
    else                   return cnt_t'(0);
  endfunction

  // decode of the final read
  function automatic act_e final_action(addr_t a);
    if (a == KEY_STORE)       return ACT_STORE;
    else if (a == KEY_RECALL) return ACT_RECALL;
    else                      return ACT_NONE;
  endfunction
endpackage

// File: rtl/nvu_access_capture.sv
module nvu_access_capture
  import nvu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  chip_en_n,
  input  logic  wr_en_n,
  input  addr_t addr_i,
  output logic  done_o,
  output addr_t addr_o,
  output logic  wr_o
);
  logic  ce_prev_n;
  logic  start;

  assign start  = ce_prev_n & ~chip_en_n;
  assign done_o = chip_en_n & ~ce_prev_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_prev_n <= 1'b1;
      addr_o    <= '0;
      wr_o      <= 1'b0;
    end else begin
      ce_prev_n <= chip_en_n;
      if (!chip_en_n) begin
        addr_o <= addr_i;
        wr_o   <= start ? ~wr_en_n : (wr_o | ~wr_en_n);
      end
    end
  end

  // R4
  access_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(!chip_en_n));
endmodule

// File: rtl/nvu_seq_fsm.sv
module nvu_seq_fsm
  import nvu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  done_i,
  input  addr_t addr_i,
  input  logic  wr_i,
  input  logic  busy_i,
  input  logic  inhibit_i,
  output logic  store_o,
  output logic  recall_o,
  output cnt_t  step_o
);
  cnt_t step_n;
  logic st_n, rc_n;
  act_e act;

  always_comb begin
    step_n = step_o;
    st_n   = 1'b0;
    rc_n   = 1'b0;
    act    = final_action(addr_i);
    if (busy_i) begin
      step_n = '0;
    end else if (done_i) begin
      if (wr_i) begin
        step_n = '0;
      end else if (step_o == LAST_IDX) begin
        st_n   = (act == ACT_STORE) && !inhibit_i;
        rc_n   = (act == ACT_RECALL);
        step_n = (act == ACT_NONE && addr_i == KEY_START) ? cnt_t'(1) : cnt_t'(0);
      end else begin
        step_n = step_after(step_o, addr_i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_o   <= '0;
      store_o  <= 1'b0;
      recall_o <= 1'b0;
    end else begin
      step_o   <= step_n;
      store_o  <= st_n;
      recall_o <= rc_n;
    end
  end

  // R10
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_o && recall_o));
  // R10
  store_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_o |=> !store_o);
  // R10
  recall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recall_o |=> !recall_o);
  // R2
  store_from_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_o |-> ($past(step_o) == LAST_IDX && step_o == '0));
  // R3
  recall_from_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recall_o |-> ($past(step_o) == LAST_IDX && step_o == '0));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> (step_o == '0 && !store_o && !recall_o));
  // R8
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && inhibit_i) |=> !store_o);
  // R4
  step_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_i && !busy_i) |=> $stable(step_o));
  // R4
  step_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o != $past(step_o)) |->
      (step_o == '0 || step_o == cnt_t'(1) || step_o == cnt_t'($past(step_o) + 1'b1)));
endmodule

// File: rtl/nvu_unlock_detect.sv
module nvu_unlock_detect
  import nvu_pkg::*;
#(
  parameter int AW = nvu_pkg::ADDR_W,
  parameter int CW = nvu_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          chip_en_n,
  input  logic          wr_en_n,
  input  logic          store_block_i,
  input  logic          xfer_busy_i,
  output logic          store_req_o,
  output logic          recall_req_o,
  output logic [CW-1:0] progress_o
);
  logic  acc_done;
  addr_t acc_addr;
  logic  acc_wr;
  cnt_t  step;

  nvu_access_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_en_n (chip_en_n),
    .wr_en_n   (wr_en_n),
    .addr_i    (addr_t'(addr_i)),
    .done_o    (acc_done),
    .addr_o    (acc_addr),
    .wr_o      (acc_wr)
  );

  nvu_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_i    (acc_done),
    .addr_i    (acc_addr),
    .wr_i      (acc_wr),
    .busy_i    (xfer_busy_i),
    .inhibit_i (store_block_i),
    .store_o   (store_req_o),
    .recall_o  (recall_req_o),
    .step_o    (step)
  );

  assign progress_o = CW'(step);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (progress_o == '0 && !store_req_o && !recall_req_o));
endmodule

// File: tb/test_nvu_unlock_detect.sv
module test_nvu_unlock_detect;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic        ce_n = 1'b1;
  logic        we_n = 1'b1;
  logic        blk = 1'b0;
  logic        busy = 1'b0;
  logic        st, rc;
  logic [2:0]  prog;

  int checks = 0;
  int fails  = 0;

  logic [12:0] prefix [5] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0};

  always #(CLK_P/2) clk = ~clk;

  nvu_unlock_detect i_nvu_unlock_detect (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .chip_en_n(ce_n), .wr_en_n(we_n),
    .store_block_i(blk), .xfer_busy_i(busy),
    .store_req_o(st), .recall_req_o(rc), .progress_o(prog)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one access; returns at the negedge where its effect is visible
  task automatic acc(logic [12:0] a, bit wr, int low = 1);
    @(negedge clk);
    addr = a; we_n = ~wr; ce_n = 1'b0;
    repeat (low) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic prefix_reads(string req);
    for (int i = 0; i < 5; i++) begin
      acc(prefix[i], 1'b0);
      chk(req, prog, i + 1);
    end
  endtask

  task automatic t_reset;
    chk("R1 progress", prog, 0);
    chk("R1 store", st, 0);
    chk("R1 recall", rc, 0);
  endtask

  task automatic t_store;
    prefix_reads("R4 store-prefix");
    acc(13'h0F0F, 1'b0);
    chk("R2 store pulse", st, 1);
    chk("R10 no recall", rc, 0);
    chk("R2 progress cleared", prog, 0);
    @(negedge clk);
    chk("R2 pulse one cycle", st, 0);
  endtask

  task automatic t_recall;
    prefix_reads("R4 recall-prefix");
    acc(13'h0F0E, 1'b0);
    chk("R3 recall pulse", rc, 1);
    chk("R10 no store", st, 0);
    chk("R3 progress cleared", prog, 0);
    @(negedge clk);
    chk("R3 pulse one cycle", rc, 0);
  endtask

  task automatic t_long_low;
    acc(13'h0000, 1'b0, 5);
    chk("R4 long access counts once", prog, 1);
    acc(13'h1555, 1'b0, 3);
    chk("R4 second long access", prog, 2);
    acc(13'h0001, 1'b0);
    chk("R6 bad read aborts", prog, 0);
  endtask

  task automatic t_write_abort;
    acc(13'h0000, 1'b0);
    acc(13'h1555, 1'b0);
    acc(13'h0AAA, 1'b1);
    chk("R5 write on matching address aborts", prog, 0);
    prefix_reads("R5 restart after write");
    acc(13'h0F0F, 1'b1);
    chk("R5 write as final step no store", st, 0);
    chk("R5 progress after final write", prog, 0);
  endtask

  task automatic t_wrong_read;
    acc(13'h0000, 1'b0);
    acc(13'h1555, 1'b0);
    acc(13'h0AAA, 1'b0);
    acc(13'h0000, 1'b0);
    chk("R6 zero restarts at one", prog, 1);
    acc(13'h1555, 1'b0);
    acc(13'h1FFF, 1'b0);
    chk("R6 skipped step aborts", prog, 0);
  endtask

  task automatic t_test_code;
    prefix_reads("R7 prefix");
    acc(13'h139C, 1'b0);
    chk("R7 no store", st, 0);
    chk("R7 no recall", rc, 0);
    chk("R7 progress zero", prog, 0);
  endtask

  task automatic t_inhibit;
    blk = 1'b1;
    prefix_reads("R8 prefix");
    acc(13'h0F0F, 1'b0);
    chk("R8 store blocked", st, 0);
    chk("R8 progress zero", prog, 0);
    prefix_reads("R8 prefix2");
    acc(13'h0F0E, 1'b0);
    chk("R8 recall unaffected", rc, 1);
    blk = 1'b0;
  endtask

  task automatic t_busy;
    acc(13'h0000, 1'b0);
    acc(13'h1555, 1'b0);
    @(negedge clk); busy = 1'b1;
    @(negedge clk);
    chk("R9 busy clears progress", prog, 0);
    for (int i = 0; i < 5; i++) acc(prefix[i], 1'b0);
    chk("R9 accesses ignored", prog, 0);
    acc(13'h0F0F, 1'b0);
    chk("R9 no store while busy", st, 0);
    busy = 1'b0;
    @(negedge clk);
    chk("R9 progress after busy", prog, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_store();
    t_recall();
    t_long_low();
    t_write_abort();
    t_wrong_read();
    t_test_code();
    t_inhibit();
    t_busy();
    t_store();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule